// File: doc/BRIEF.md
# Dual-Channel IDE Card Register Decoder

This block sits between a byte-wide host bus and an expansion card that carries two IDE channels. It watches the host address together with the read and write strobes and turns each recognised location into a strobe. Each channel's eight taskfile registers get a chip select and a register index, and so does its alternate-status/control register. Each channel's interrupt control location gets a read or write strobe, and its interrupt status location is a readable byte. Data read from the drive is passed back to the host for taskfile and control accesses.

A write-only select register sits at the base of the card's fast region. One of its bits opens the extended region that holds all channel windows. Another bit chooses which channel receives the DMA request/acknowledge pair. A four-bit board identification code can be read one bit at a time from four byte locations, and these locations can be read whatever the select register holds. All decode is combinational from the host strobes. The select register is the only storage.

Top module: `ide_card_decoder`

## Requirements
- R1: With the extended region open, a host read or write at address CHAN_BASE + c*CHAN_PITCH + n*64 (n = 0..7; channel 0 at 0x2000, channel 1 at 0x3000) asserts `taskSel[c]`. It also drives `ideRegAddr[3c+2:3c]` to n.
- R2: With the extended region open, an access at 0x2380 (channel 0) or 0x3380 (channel 1) asserts `ctrlSel` for that channel, with register index 6 on its `ideRegAddr` field.
- R3: A host read at 0x2280 + 4k (k = 0..3) returns `boardId[k]` in data bit 0, with bits 7..1 zero. This works whether or not the extended region is open. The code 3 marks the dual-channel board and 15 the single-channel board.
- R4: A host write at address 0x0000 loads the select register on the clock edge. Data bit 5 then drives `extEnable` and data bit 0 drives `dmaChan`, both visible after that edge.
- R5: After reset the select register is 0, so `extEnable` and `dmaChan` are both 0.
- R6: While `extEnable` is 0, accesses to any channel location assert no select or interrupt strobe, and reads of those locations return 0xFF. Writing 0 to the select register closes the region again.
- R7: At most one of the `taskSel` and `ctrlSel` bits is high at a time. None is high unless `hostRd` or `hostWr` is high, and `ideRd`/`ideWr` follow the host strobe only while a select is high.
- R8: With the region open, a write at 0x2200 (channel 0) or 0x3200 (channel 1) pulses `irqCtrlWr` for that channel, and a read there pulses `irqCtrlRd`.
- R9: With the region open, a read at 0x2290 (channel 0) or 0x3290 (channel 1) returns that channel's `irqPending` in data bit 0, with the other bits zero.
- R10: Taskfile and control reads return `ideRdData`. Reads of any address with no mapping return 0xFF.
- R11: A channel-window address that is not a multiple of 64 from the channel base, such as 0x2020, selects no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the select register |
| rstN | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 14 | Host byte address |
| hostWrData | input | 8 | Host write data |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostRdData | output | 8 | Host read data |
| boardId | input | 4 | Board identification straps |
| ideRdData | input | 8 | Data returned by the selected drive register |
| irqPending | input | 2 | Per-channel interrupt status |
| taskSel | output | 2 | Per-channel taskfile chip select |
| ctrlSel | output | 2 | Per-channel control/alternate-status chip select |
| ideRegAddr | output | 6 | Per-channel 3-bit register index |
| ideRd | output | 1 | Read strobe toward the drives |
| ideWr | output | 1 | Write strobe toward the drives |
| irqCtrlWr | output | 2 | Per-channel interrupt control write strobe |
| irqCtrlRd | output | 2 | Per-channel interrupt control read strobe |
| extEnable | output | 1 | Extended region open (select bit 5) |
| dmaChan | output | 1 | Channel owning the DMA signals (select bit 0) |

## Verification
The bench builds the block with its default parameters: a 14-bit address, 64-byte register spacing, channel bases 0x2000 and 0x3000. At these values every one of the sixteen taskfile slots can be visited, along with both control, interrupt control and status locations and all four identification locations. The misaligned and unmapped addresses that sit between the slots are also within reach. It drives the same locations with the extended region closed and then open, and with two board codes and differing interrupt patterns. This shows the gating, the index encoding and the bit-0 reads at each location.

// File: rtl/ide_dec_pkg.sv
package ide_dec_pkg;
  localparam int NCHAN        = 2;
  localparam int REG_IDX_W    = 3;
  localparam int CTRL_REG_NUM = 6;
  localparam int ID_W         = 4;
  localparam int ID_IDX_W     = 2;

  // Strobes from the address decoder to the datapath.
  typedef struct packed {
    logic [NCHAN-1:0]     taskHit;
    logic [NCHAN-1:0]     ctrlHit;
    logic [NCHAN-1:0]     irqCtlHit;
    logic [NCHAN-1:0]     irqStatHit;
    logic                 identHit;
    logic [ID_IDX_W-1:0]  identIdx;
    logic                 selHit;
    logic [REG_IDX_W-1:0] regNum;
  } decStrobeT;
endpackage

// File: rtl/ide_dec_ctrl.sv
module ide_dec_ctrl
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W       = 14,
  parameter int REG_SHIFT    = 6,
  parameter int CHAN_BASE    = 'h2000,
  parameter int CHAN_PITCH   = 'h1000,
  parameter int CTRL_OFS     = 'h380,
  parameter int IRQCTL_OFS   = 'h200,
  parameter int IRQSTAT_OFS  = 'h290,
  parameter int IDENT_BASE   = 'h2280,
  parameter int IDENT_STRIDE = 4,
  parameter int SEL_ADDR     = 0
) (
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic              extEnable,
  output decStrobeT         strb
);
  localparam int REG_COUNT = 1 << REG_IDX_W;
  localparam int TASK_SPAN = REG_COUNT << REG_SHIFT;

  logic access;
  logic openAccess;
  logic [REG_IDX_W-1:0] regIdx [NCHAN];
  logic [NCHAN-1:0] taskHitV, ctrlHitV, irqCtlHitV, irqStatHitV;

  assign access     = hostRd | hostWr;
  assign openAccess = access & extEnable;

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_chan
    localparam logic [ADDR_W-1:0] BASE  = ADDR_W'(CHAN_BASE + ch * CHAN_PITCH);
    localparam logic [ADDR_W-1:0] CTRLA = ADDR_W'(CHAN_BASE + ch * CHAN_PITCH + CTRL_OFS);
    localparam logic [ADDR_W-1:0] ICTLA = ADDR_W'(CHAN_BASE + ch * CHAN_PITCH + IRQCTL_OFS);
    localparam logic [ADDR_W-1:0] ISTA  = ADDR_W'(CHAN_BASE + ch * CHAN_PITCH + IRQSTAT_OFS);
    logic [ADDR_W-1:0] offs;
    logic inTask;
    assign offs   = hostAddr - BASE;
    assign inTask = (hostAddr >= BASE) && (offs < ADDR_W'(TASK_SPAN))
                    && (offs[REG_SHIFT-1:0] == '0);
    assign regIdx[ch]      = offs[REG_SHIFT +: REG_IDX_W];
    assign taskHitV[ch]    = openAccess && inTask;
    assign ctrlHitV[ch]    = openAccess && (hostAddr == CTRLA);
    assign irqCtlHitV[ch]  = openAccess && (hostAddr == ICTLA);
    assign irqStatHitV[ch] = hostRd && extEnable && (hostAddr == ISTA);
  end

  always_comb begin
    strb            = '0;
    strb.taskHit    = taskHitV;
    strb.ctrlHit    = ctrlHitV;
    strb.irqCtlHit  = irqCtlHitV;
    strb.irqStatHit = irqStatHitV;
    strb.selHit     = hostWr && (hostAddr == ADDR_W'(SEL_ADDR));
    for (int ch = 0; ch < NCHAN; ch++) begin
      if (taskHitV[ch]) strb.regNum = regIdx[ch];
      if (ctrlHitV[ch]) strb.regNum = REG_IDX_W'(CTRL_REG_NUM);
    end
    for (int k = 0; k < ID_W; k++) begin
      if (hostRd && (hostAddr == ADDR_W'(IDENT_BASE + k * IDENT_STRIDE))) begin
        strb.identHit = 1'b1;
        strb.identIdx = ID_IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/ide_dec_dp.sv
module ide_dec_dp
  import ide_dec_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EXT_BIT = 5,
  parameter int DMA_BIT = 0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  decStrobeT                  strb,
  input  logic [DATA_W-1:0]          hostWrData,
  input  logic                       hostRd,
  input  logic                       hostWr,
  input  logic [ID_W-1:0]            boardId,
  input  logic [DATA_W-1:0]          ideRdData,
  input  logic [NCHAN-1:0]           irqPending,
  output logic [DATA_W-1:0]          hostRdData,
  output logic [NCHAN-1:0]           taskSel,
  output logic [NCHAN-1:0]           ctrlSel,
  output logic [NCHAN*REG_IDX_W-1:0] ideRegAddr,
  output logic                       ideRd,
  output logic                       ideWr,
  output logic [NCHAN-1:0]           irqCtrlWr,
  output logic [NCHAN-1:0]           irqCtrlRd,
  output logic                       extEnable,
  output logic                       dmaChan
);
  logic [DATA_W-1:0] selReg;
  logic anySel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            selReg <= '0;
    else if (strb.selHit) selReg <= hostWrData;
  end

  assign extEnable = selReg[EXT_BIT];
  assign dmaChan   = selReg[DMA_BIT];

  assign taskSel   = strb.taskHit;
  assign ctrlSel   = strb.ctrlHit;
  assign anySel    = |{strb.taskHit, strb.ctrlHit};
  assign ideRd     = hostRd & anySel;
  assign ideWr     = hostWr & anySel;
  assign irqCtrlWr = strb.irqCtlHit & {NCHAN{hostWr}};
  assign irqCtrlRd = strb.irqCtlHit & {NCHAN{hostRd}};

  for (genvar ch = 0; ch < NCHAN; ch++) begin : g_ra
    assign ideRegAddr[ch*REG_IDX_W +: REG_IDX_W] =
      (strb.taskHit[ch] | strb.ctrlHit[ch]) ? strb.regNum : '0;
  end

  always_comb begin
    hostRdData = '1;
    if (anySel) hostRdData = ideRdData;
    for (int ch = 0; ch < NCHAN; ch++)
      if (strb.irqStatHit[ch]) hostRdData = DATA_W'(irqPending[ch]);
    if (strb.identHit) hostRdData = DATA_W'(boardId[strb.identIdx]);
  end
endmodule

// File: rtl/ide_card_decoder.sv
module ide_card_decoder
  import ide_dec_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int REG_SHIFT  = 6,
  parameter int CHAN_BASE  = 'h2000,
  parameter int CHAN_PITCH = 'h1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWrData,
  input  logic              hostRd,
  input  logic              hostWr,
  output logic [DATA_W-1:0] hostRdData,
  input  logic [3:0]        boardId,
  input  logic [DATA_W-1:0] ideRdData,
  input  logic [1:0]        irqPending,
  output logic [1:0]        taskSel,
  output logic [1:0]        ctrlSel,
  output logic [5:0]        ideRegAddr,
  output logic              ideRd,
  output logic              ideWr,
  output logic [1:0]        irqCtrlWr,
  output logic [1:0]        irqCtrlRd,
  output logic              extEnable,
  output logic              dmaChan
);
  decStrobeT strb;

  ide_dec_ctrl #(
    .ADDR_W(ADDR_W), .REG_SHIFT(REG_SHIFT),
    .CHAN_BASE(CHAN_BASE), .CHAN_PITCH(CHAN_PITCH)
  ) ctrl_i (
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .extEnable(extEnable), .strb(strb)
  );

  ide_dec_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostWrData(hostWrData),
    .hostRd(hostRd), .hostWr(hostWr), .boardId(boardId),
    .ideRdData(ideRdData), .irqPending(irqPending),
    .hostRdData(hostRdData), .taskSel(taskSel), .ctrlSel(ctrlSel),
    .ideRegAddr(ideRegAddr), .ideRd(ideRd), .ideWr(ideWr),
    .irqCtrlWr(irqCtrlWr), .irqCtrlRd(irqCtrlRd),
    .extEnable(extEnable), .dmaChan(dmaChan)
  );
endmodule

// File: rtl/ide_card_decoder_chk.sv
module ide_card_decoder_chk (
  input logic        clk,
  input logic        rstN,
  input logic [13:0] hostAddr,
  input logic [7:0]  hostWrData,
  input logic        hostRd,
  input logic        hostWr,
  input logic [7:0]  hostRdData,
  input logic [3:0]  boardId,
  input logic [1:0]  taskSel,
  input logic [1:0]  ctrlSel,
  input logic        ideRd,
  input logic        ideWr,
  input logic [1:0]  irqCtrlWr,
  input logic [1:0]  irqCtrlRd,
  input logic        extEnable,
  input logic        dmaChan
);
  a_r7_one_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({taskSel, ctrlSel}));

  a_r7_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (|{taskSel, ctrlSel}) |-> (hostRd || hostWr));

  a_r7_drive_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (ideRd || ideWr) |-> (|{taskSel, ctrlSel}));

  a_r6_closed_gate: assert property (@(posedge clk) disable iff (!rstN)
    !extEnable |-> ({taskSel, ctrlSel, irqCtrlWr, irqCtrlRd} == 8'h00));

  a_r6_closed_read: assert property (@(posedge clk) disable iff (!rstN)
    (!extEnable && hostRd && hostAddr == 14'h2000) |-> (hostRdData == 8'hFF));

  a_r4_select_load: assert property (@(posedge clk) disable iff (!rstN)
    (hostWr && hostAddr == 14'h0000) |=>
      (extEnable == $past(hostWrData[5]) && dmaChan == $past(hostWrData[0])));

  a_r4_select_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(hostWr && hostAddr == 14'h0000) |=> ($stable(extEnable) && $stable(dmaChan)));

  a_r3_ident_bit0: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && hostAddr == 14'h2280) |-> (hostRdData == {7'b0, boardId[0]}));
endmodule

bind ide_card_decoder ide_card_decoder_chk chk_i (.*);

// File: tb/ide_card_decoder_tb_top.sv
module ide_card_decoder_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [13:0] hostAddr = '0;
  logic [7:0]  hostWrData = '0;
  logic        hostRd = 0, hostWr = 0;
  logic [7:0]  hostRdData;
  logic [3:0]  boardId = 4'd3;
  logic [7:0]  ideRdData = 8'h5A;
  logic [1:0]  irqPending = 2'b00;
  logic [1:0]  taskSel, ctrlSel, irqCtrlWr, irqCtrlRd;
  logic [5:0]  ideRegAddr;
  logic        ideRd, ideWr, extEnable, dmaChan;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ide_card_decoder dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Present an access and leave it applied for sampling mid-cycle.
  task automatic drive(input logic [13:0] a, input bit rd, input bit wr, input logic [7:0] d);
    @(negedge clk);
    hostAddr = a; hostRd = rd; hostWr = wr; hostWrData = d;
    #2;
  endtask

  task automatic idle();
    @(negedge clk);
    hostRd = 0; hostWr = 0; hostAddr = '0;
  endtask

  task automatic writeSel(input logic [7:0] d);
    drive(14'h0000, 0, 1, d);
    @(posedge clk); #1;
    idle();
    #2;
  endtask

  task automatic t_reset();
    chk(extEnable == 0, "R5 extEnable after reset", extEnable, 0);
    chk(dmaChan == 0, "R5 dmaChan after reset", dmaChan, 0);
  endtask

  task automatic t_closed();
    drive(14'h2000, 1, 0, 0);
    chk(taskSel == 0, "R6 closed taskSel", taskSel, 0);
    chk(hostRdData == 8'hFF, "R6 closed read data", hostRdData, 8'hFF);
    drive(14'h3380, 1, 0, 0);
    chk(ctrlSel == 0, "R6 closed ctrlSel", ctrlSel, 0);
    drive(14'h2200, 0, 1, 0);
    chk(irqCtrlWr == 0, "R6 closed irqCtrlWr", irqCtrlWr, 0);
    idle();
  endtask

  task automatic t_ident(input logic [3:0] code);
    boardId = code;
    for (int k = 0; k < 4; k++) begin
      drive(14'(14'h2280 + 4*k), 1, 0, 0);
      chk(hostRdData == {7'b0, code[k]}, "R3 ident bit", hostRdData, {7'b0, code[k]});
    end
    idle();
  endtask

  task automatic t_select();
    writeSel(8'h21);
    chk(extEnable == 1, "R4 extEnable from bit 5", extEnable, 1);
    chk(dmaChan == 1, "R4 dmaChan from bit 0", dmaChan, 1);
    writeSel(8'h20);
    chk(dmaChan == 0 && extEnable == 1, "R4 dmaChan cleared", {extEnable, dmaChan}, 2'b10);
  endtask

  task automatic t_taskfile();
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n < 8; n++) begin
        ideRdData = 8'(8'h40 + ch*16 + n);
        drive(14'(14'h2000 + ch*14'h1000 + n*64), 1, 0, 0);
        chk(taskSel == 2'(1 << ch), "R1 taskSel", taskSel, 1 << ch);
        chk(ideRegAddr[ch*3 +: 3] == 3'(n), "R1 register index", ideRegAddr, n);
        chk(hostRdData == ideRdData, "R10 taskfile read data", hostRdData, ideRdData);
        chk(ideRd == 1 && ideWr == 0, "R7 ideRd follows hostRd", {ideRd, ideWr}, 2'b10);
      end
    end
    drive(14'h3040, 0, 1, 8'h77);
    chk(taskSel == 2'b10 && ideWr == 1, "R1 taskfile write select", {taskSel, ideWr}, 3'b101);
    idle();
  endtask

  task automatic t_ctrl();
    drive(14'h2380, 1, 0, 0);
    chk(ctrlSel == 2'b01 && taskSel == 0, "R2 ctrl chan0", {ctrlSel, taskSel}, 4'b0100);
    chk(ideRegAddr == 6'o06, "R2 ctrl index chan0", ideRegAddr, 6'o06);
    drive(14'h3380, 0, 1, 8'h02);
    chk(ctrlSel == 2'b10, "R2 ctrl chan1", ctrlSel, 2'b10);
    chk(ideRegAddr == 6'o60, "R2 ctrl index chan1", ideRegAddr, 6'o60);
    idle();
  endtask

  task automatic t_irq();
    drive(14'h2200, 0, 1, 0);
    chk(irqCtrlWr == 2'b01 && irqCtrlRd == 0, "R8 irq ctrl write ch0", {irqCtrlWr, irqCtrlRd}, 4'b0100);
    drive(14'h3200, 1, 0, 0);
    chk(irqCtrlRd == 2'b10 && irqCtrlWr == 0, "R8 irq ctrl read ch1", {irqCtrlWr, irqCtrlRd}, 4'b0010);
    chk(taskSel == 0 && ctrlSel == 0, "R7 no chip select on irq ctrl", {taskSel, ctrlSel}, 0);
    irqPending = 2'b10;
    drive(14'h2290, 1, 0, 0);
    chk(hostRdData == 8'h00, "R9 irq status ch0", hostRdData, 8'h00);
    drive(14'h3290, 1, 0, 0);
    chk(hostRdData == 8'h01, "R9 irq status ch1", hostRdData, 8'h01);
    irqPending = 2'b01;
    drive(14'h2290, 1, 0, 0);
    chk(hostRdData == 8'h01, "R9 irq status ch0 set", hostRdData, 8'h01);
    idle();
  endtask

  task automatic t_misc();
    drive(14'h2020, 1, 0, 0);
    chk(taskSel == 0 && ideRd == 0, "R11 misaligned no select", {taskSel, ideRd}, 0);
    chk(hostRdData == 8'hFF, "R10 unmapped read", hostRdData, 8'hFF);
    drive(14'h2400, 1, 0, 0);
    chk(taskSel == 0 && hostRdData == 8'hFF, "R10 past last register", hostRdData, 8'hFF);
    drive(14'h2000, 0, 0, 0);
    chk({taskSel, ctrlSel} == 0, "R7 no strobe no select", {taskSel, ctrlSel}, 0);
    idle();
  endtask

  task automatic t_close_again();
    writeSel(8'h00);
    chk(extEnable == 0 && dmaChan == 0, "R6 write zero closes", {extEnable, dmaChan}, 0);
    drive(14'h3000, 1, 0, 0);
    chk(taskSel == 0 && hostRdData == 8'hFF, "R6 reclosed access", {taskSel, hostRdData}, 8'hFF);
    drive(14'h228C, 1, 0, 0);
    chk(hostRdData == {7'b0, boardId[3]}, "R3 ident while closed", hostRdData, boardId[3]);
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1;
    #2;
    t_reset();
    t_closed();
    t_ident(4'd3);
    t_ident(4'd15);
    t_select();
    t_taskfile();
    t_ctrl();
    t_irq();
    t_misc();
    t_close_again();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule